// File: doc/BRIEF.md
# Partitioned Victim Way Selector

This block decides which way of one cache set is replaced when a fill or a lock-fill misses. The caller presents the four per-way state vectors of the addressed set (valid, dirty, locked, use), the requesting agent and the request kind. After a fixed two-cycle decision the block returns the victim way, whether that line must be written back, which use bits must be cleared, and whether the new line is to be locked. If no way qualifies, it reports a failure instead.

Eviction is fenced by one partition mask per requester. Each core has its own mask and all hardware agents share one more. A 1 bit in a mask forbids eviction from that way and a 0 bit permits it. Locked lines are never victims. A lock-fill is refused when granting it would leave the requester without an unlocked way of its own. Masks are loaded through a write port that refuses any mask that would block every way. The set index of the request is passed through, taken from the physical address above the 128-byte line offset.

The control is a three-state machine. `ST_IDLE` waits with `req_ready` high. The transition *accept* (`req_valid` in `ST_IDLE`) captures the request and goes to `ST_PICK`. The transition *decide* always goes from `ST_PICK` to `ST_RESP`, registering the result. The transition *retire* always goes from `ST_RESP` back to `ST_IDLE`, clearing the result registers.

Top module: `victim_select`

## Requirements
- R1: After reset every partition mask is all zeros (every way allowed), `rsp_valid` and `cfg_wr_err` are low and `req_ready` is high.
- R2: A mask write whose mask is all ones, or whose selector exceeds NUM_CORES, is refused. `cfg_wr_err` goes high for one cycle on the cycle after the write and the old mask stays in force. An accepted write leaves `cfg_wr_err` low.
- R3: Requester codes 0 to NUM_CORES-1 are cores, each with its own mask. Code NUM_CORES is the shared hardware-agent mask, and any higher code behaves as a mask of all ones. A victim is only ever a way whose bit in the requester's mask is 0.
- R4: A way with its lock bit set is never reported as a victim.
- R5: Among the permitted, unlocked ways, the lowest-numbered invalid way is chosen first.
- R6: If all those ways are valid, the lowest-numbered one with use bit 0 is chosen, and `rsp_use_clear` is zero.
- R7: If every permitted, unlocked way has its use bit set, `rsp_use_clear` equals exactly that set of ways and the lowest of them is chosen.
- R8: With no permitted, unlocked way, `rsp_fail` is high for the one response cycle and `rsp_way`, `rsp_writeback`, `rsp_use_clear` and `rsp_set_lock` are all zero.
- R9: A lock-fill (`req_kind`=1) fails unless at least two permitted, unlocked ways exist. When it succeeds, `rsp_set_lock` is 1. A normal fill (`req_kind`=0) never sets `rsp_set_lock`.
- R10: `rsp_writeback` is 1 exactly when the chosen victim is both valid and dirty.
- R11: `rsp_set` equals physical address bits [7 +: SET_BITS] of the request.
- R12: `rsp_valid` is high for exactly one cycle, two clock edges after the accepting edge, and `req_ready` is low from acceptance until the response has retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Mask write strobe |
| cfg_wr_sel | input | REQ_W | Mask selector (core number, or NUM_CORES for hardware agents) |
| cfg_wr_mask | input | WAYS | New mask; 1 blocks eviction from a way |
| cfg_wr_err | output | 1 | Write refused (pulse, cycle after the write) |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | Block idle, request may be presented |
| req_src | input | REQ_W | Requester code |
| req_kind | input | 1 | 0 normal fill, 1 lock-fill |
| req_addr | input | ADDR_W | Physical address of the miss |
| tag_valid | input | WAYS | Valid bits of the set |
| tag_dirty | input | WAYS | Dirty bits of the set |
| tag_lock | input | WAYS | Lock bits of the set |
| tag_use | input | WAYS | Use bits of the set |
| rsp_valid | output | 1 | Result strobe |
| rsp_fail | output | 1 | No victim available |
| rsp_way | output | WAY_W | Chosen victim way |
| rsp_writeback | output | 1 | Victim is valid and dirty |
| rsp_use_clear | output | WAYS | Use bits to clear |
| rsp_set_lock | output | 1 | Lock the allocated line |
| rsp_set | output | SET_BITS | Set index of the request |

## Verification
The hardest situation to reach is the use-bit wrap: every way that is both permitted and unlocked must be valid with its use bit set, while blocked or locked ways hold clear use bits that must not be taken. The stimulus gets there by first writing a partition mask for one core, then presenting sets with all valid and all use bits high and a varying lock pattern, so the expected clear vector is the narrow intersection. A refused mask write is followed at once by requests whose answer differs between the old and the would-be mask.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_RESP = 2'd2
    } vsel_state_e;

    typedef enum logic {
        KIND_FILL = 1'b0,
        KIND_LOCK = 1'b1
    } vsel_kind_e;

endpackage

// File: rtl/vsel_mask_bank.sv
module vsel_mask_bank #(
    parameter int WAYS  = 8,
    parameter int NREQ  = 5,
    parameter int SEL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [WAYS-1:0]        wr_mask,
    output logic                   wr_err,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [WAYS-1:0]        rd_mask,
    output logic [NREQ*WAYS-1:0]   masks_flat
);
    localparam logic [SEL_W:0] NREQ_L = (SEL_W+1)'(NREQ);

    logic [WAYS-1:0] mask_q [NREQ];
    logic            sel_ok;
    logic            mask_ok;
    logic            wr_ok;

    assign sel_ok  = {1'b0, wr_sel} < NREQ_L;
    assign mask_ok = ~(&wr_mask);
    assign wr_ok   = wr_en && sel_ok && mask_ok;

    for (genvar r = 0; r < NREQ; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[r] <= '0;
            end else if (wr_ok && (wr_sel == SEL_W'(r))) begin
                mask_q[r] <= wr_mask;
            end
        end
        assign masks_flat[r*WAYS +: WAYS] = mask_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !wr_ok;
        end
    end

    always_comb begin
        rd_mask = '1;
        for (int r = 0; r < NREQ; r++) begin
            if (rd_sel == SEL_W'(r)) begin
                rd_mask = mask_q[r];
            end
        end
    end
endmodule

// File: rtl/vsel_lowest.sv
module vsel_lowest #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
    parameter int WAYS  = 8,
    parameter int WAY_W = 3
) (
    input  logic [WAYS-1:0]  part_mask,
    input  logic [WAYS-1:0]  lock_bits,
    input  logic [WAYS-1:0]  valid_bits,
    input  logic [WAYS-1:0]  dirty_bits,
    input  logic [WAYS-1:0]  use_bits,
    input  logic             is_lock,
    output logic             fail,
    output logic [WAY_W-1:0] way,
    output logic             writeback,
    output logic [WAYS-1:0]  use_clear,
    output logic             set_lock
);
    localparam int CNT_W = $clog2(WAYS + 1);

    logic [WAYS-1:0]  cand;
    logic [WAYS-1:0]  empty_ways;
    logic [WAYS-1:0]  cold_ways;
    logic [CNT_W-1:0] cand_cnt;
    logic             enough;
    logic             any_cand, any_empty, any_cold;
    logic [WAY_W-1:0] idx_cand, idx_empty, idx_cold;

    assign cand       = ~part_mask & ~lock_bits;
    assign empty_ways = cand & ~valid_bits;
    assign cold_ways  = cand & ~use_bits;
    assign cand_cnt   = CNT_W'($countones(cand));
    assign enough     = is_lock ? (cand_cnt >= CNT_W'(2)) : (cand_cnt >= CNT_W'(1));

    vsel_lowest #(.N(WAYS), .IW(WAY_W)) u_low_cand (
        .vec(cand), .any(any_cand), .idx(idx_cand)
    );
    vsel_lowest #(.N(WAYS), .IW(WAY_W)) u_low_empty (
        .vec(empty_ways), .any(any_empty), .idx(idx_empty)
    );
    vsel_lowest #(.N(WAYS), .IW(WAY_W)) u_low_cold (
        .vec(cold_ways), .any(any_cold), .idx(idx_cold)
    );

    always_comb begin
        fail      = 1'b0;
        way       = '0;
        writeback = 1'b0;
        use_clear = '0;
        set_lock  = 1'b0;
        if (!enough || !any_cand) begin
            fail = 1'b1;
        end else begin
            if (any_empty) begin
                way = idx_empty;
            end else if (any_cold) begin
                way = idx_cold;
            end else begin
                way       = idx_cand;
                use_clear = cand;
            end
            writeback = valid_bits[way] & dirty_bits[way];
            set_lock  = is_lock;
        end
    end
endmodule

// File: rtl/victim_select.sv
module victim_select
    import vsel_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int WAYS       = 8,
    parameter int ADDR_W     = 40,
    parameter int SET_BITS   = 10,
    parameter int LINE_BYTES = 128,
    localparam int NREQ      = NUM_CORES + 1,
    localparam int REQ_W     = $clog2(NREQ + 1),
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [REQ_W-1:0]    cfg_wr_sel,
    input  logic [WAYS-1:0]     cfg_wr_mask,
    output logic                cfg_wr_err,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [REQ_W-1:0]    req_src,
    input  logic                req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WAYS-1:0]     tag_valid,
    input  logic [WAYS-1:0]     tag_dirty,
    input  logic [WAYS-1:0]     tag_lock,
    input  logic [WAYS-1:0]     tag_use,
    output logic                rsp_valid,
    output logic                rsp_fail,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                rsp_writeback,
    output logic [WAYS-1:0]     rsp_use_clear,
    output logic                rsp_set_lock,
    output logic [SET_BITS-1:0] rsp_set
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);

    vsel_state_e state, state_nx;

    logic [REQ_W-1:0]    cap_src;
    vsel_kind_e          cap_kind;
    logic [SET_BITS-1:0] cap_set;
    logic [WAYS-1:0]     cap_valid, cap_dirty, cap_lock, cap_use;
    logic [WAYS-1:0]     mask_q;
    logic [WAYS-1:0]     sel_mask;
    logic [NREQ*WAYS-1:0] masks_flat;

    logic                pk_fail, pk_wb, pk_set_lock;
    logic [WAY_W-1:0]    pk_way;
    logic [WAYS-1:0]     pk_clear;

    vsel_mask_bank #(.WAYS(WAYS), .NREQ(NREQ), .SEL_W(REQ_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_mask    (cfg_wr_mask),
        .wr_err     (cfg_wr_err),
        .rd_sel     (cap_src),
        .rd_mask    (sel_mask),
        .masks_flat (masks_flat)
    );

    vsel_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .part_mask  (sel_mask),
        .lock_bits  (cap_lock),
        .valid_bits (cap_valid),
        .dirty_bits (cap_dirty),
        .use_bits   (cap_use),
        .is_lock    (cap_kind == KIND_LOCK),
        .fail       (pk_fail),
        .way        (pk_way),
        .writeback  (pk_wb),
        .use_clear  (pk_clear),
        .set_lock   (pk_set_lock)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: accept, decide, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_PICK;
            ST_PICK: state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_src   <= '0;
            cap_kind  <= KIND_FILL;
            cap_set   <= '0;
            cap_valid <= '0;
            cap_dirty <= '0;
            cap_lock  <= '0;
            cap_use   <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            cap_src   <= req_src;
            cap_kind  <= vsel_kind_e'(req_kind);
            cap_set   <= req_addr[LINE_SHIFT +: SET_BITS];
            cap_valid <= tag_valid;
            cap_dirty <= tag_dirty;
            cap_lock  <= tag_lock;
            cap_use   <= tag_use;
        end
    end

    // output registers: load on decide, clear on retire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_fail      <= 1'b0;
            rsp_way       <= '0;
            rsp_writeback <= 1'b0;
            rsp_use_clear <= '0;
            rsp_set_lock  <= 1'b0;
            rsp_set       <= '0;
            mask_q        <= '0;
        end else begin
            unique case (state)
                ST_PICK: begin
                    rsp_fail      <= pk_fail;
                    rsp_way       <= pk_way;
                    rsp_writeback <= pk_wb;
                    rsp_use_clear <= pk_clear;
                    rsp_set_lock  <= pk_set_lock;
                    rsp_set       <= cap_set;
                    mask_q        <= sel_mask;
                end
                ST_RESP: begin
                    rsp_fail      <= 1'b0;
                    rsp_way       <= '0;
                    rsp_writeback <= 1'b0;
                    rsp_use_clear <= '0;
                    rsp_set_lock  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign rsp_valid = (state == ST_RESP);
    assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
    parameter int WAYS  = 8,
    parameter int NREQ  = 5,
    parameter int WAY_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rsp_valid,
    input logic                 rsp_fail,
    input logic [WAY_W-1:0]     rsp_way,
    input logic                 rsp_writeback,
    input logic [WAYS-1:0]      rsp_use_clear,
    input logic                 rsp_set_lock,
    input logic [WAYS-1:0]      cap_lock,
    input logic [WAYS-1:0]      mask_q,
    input logic                 cfg_wr_en,
    input logic                 cfg_wr_err,
    input logic [NREQ*WAYS-1:0] masks_flat
);
    a_r2_keep_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_err |-> ($stable(masks_flat) && $past(cfg_wr_en)));

    a_r3_victim_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fail) |-> !mask_q[rsp_way]);

    a_r4_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fail) |-> !cap_lock[rsp_way]);

    a_r7_clear_holds_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (|rsp_use_clear)) |-> rsp_use_clear[rsp_way]);

    a_r8_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> (rsp_valid && rsp_way == '0 && !rsp_writeback
                      && rsp_use_clear == '0 && !rsp_set_lock));

    a_r9_lock_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_set_lock) |-> ($countones(~mask_q & ~cap_lock) >= 2));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind victim_select vsel_checker #(.WAYS(WAYS), .NREQ(NREQ), .WAY_W(WAY_W)) u_vsel_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rsp_valid     (rsp_valid),
    .rsp_fail      (rsp_fail),
    .rsp_way       (rsp_way),
    .rsp_writeback (rsp_writeback),
    .rsp_use_clear (rsp_use_clear),
    .rsp_set_lock  (rsp_set_lock),
    .cap_lock      (cap_lock),
    .mask_q        (mask_q),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_err    (cfg_wr_err),
    .masks_flat    (masks_flat)
);

// File: tb/test_victim_select.sv
module test_victim_select;
    localparam int CLK_PERIOD = 10;
    localparam int CORES = 4;
    localparam int NW    = 8;
    localparam int AW    = 40;
    localparam int SB    = 10;
    localparam int RW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [RW-1:0] cfg_wr_sel = '0;
    logic [NW-1:0] cfg_wr_mask = '0;
    logic cfg_wr_err;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [RW-1:0] req_src = '0;
    logic req_kind = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NW-1:0] tag_valid = '0, tag_dirty = '0, tag_lock = '0, tag_use = '0;
    logic rsp_valid, rsp_fail, rsp_writeback, rsp_set_lock;
    logic [2:0] rsp_way;
    logic [NW-1:0] rsp_use_clear;
    logic [SB-1:0] rsp_set;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_select i_victim_select (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_mask(cfg_wr_mask),
        .cfg_wr_err(cfg_wr_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_kind(req_kind), .req_addr(req_addr),
        .tag_valid(tag_valid), .tag_dirty(tag_dirty), .tag_lock(tag_lock), .tag_use(tag_use),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_way(rsp_way),
        .rsp_writeback(rsp_writeback), .rsp_use_clear(rsp_use_clear),
        .rsp_set_lock(rsp_set_lock), .rsp_set(rsp_set)
    );

    typedef struct {
        bit            fail;
        int            way;
        bit            wb;
        logic [NW-1:0] clr;
        bit            lk;
        logic [SB-1:0] set;
        int            cyc;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    logic [NW-1:0] model_mask [CORES+1];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input int src, input bit kind, input logic [AW-1:0] addr,
                                   input logic [NW-1:0] v, input logic [NW-1:0] d,
                                   input logic [NW-1:0] l, input logic [NW-1:0] u);
        exp_t e;
        logic [NW-1:0] m, c;
        int n;
        m = (src <= CORES) ? model_mask[src] : '1;
        c = ~m & ~l;
        n = 0;
        for (int i = 0; i < NW; i++) if (c[i]) n++;
        e.fail = kind ? (n < 2) : (n == 0);
        e.way = 0; e.wb = 0; e.clr = '0; e.lk = 0;
        e.set = addr[7 +: SB];
        if (!e.fail) begin
            e.way = -1;
            for (int i = 0; i < NW; i++) if (e.way < 0 && c[i] && !v[i]) e.way = i;
            for (int i = 0; i < NW; i++) if (e.way < 0 && c[i] && !u[i]) e.way = i;
            if (e.way < 0) begin
                for (int i = 0; i < NW; i++) if (e.way < 0 && c[i]) e.way = i;
                e.clr = c;
            end
            e.wb = v[e.way] && d[e.way];
            e.lk = kind;
        end
        return e;
    endfunction

    // driver: pushes the expected response, then presents the request
    task automatic issue(input int src, input bit kind, input logic [AW-1:0] addr,
                         input logic [NW-1:0] v, input logic [NW-1:0] d,
                         input logic [NW-1:0] l, input logic [NW-1:0] u, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e = model(src, kind, addr, v, d, l, u);
        e.cyc = cyc + 2;
        e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_src = RW'(src); req_kind = kind; req_addr = addr;
        tag_valid = v; tag_dirty = d; tag_lock = l; tag_use = u;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {tag, " R12 busy"}, $sformatf("%0b", req_ready), "0");
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    task automatic write_mask(input int sel, input logic [NW-1:0] m, input bit exp_err, input string tag);
        drain();
        cfg_wr_en = 1'b1; cfg_wr_sel = RW'(sel); cfg_wr_mask = m;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(cfg_wr_err == exp_err, {tag, " R2 err"}, $sformatf("%0b", cfg_wr_err), $sformatf("%0b", exp_err));
        if (!exp_err) model_mask[sel] = m;
        @(negedge clk);
        check(cfg_wr_err == 1'b0, {tag, " R2 err pulse"}, $sformatf("%0b", cfg_wr_err), "0");
    endtask

    // monitor: compares each response with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", "rsp_valid=1", "none");
            end else begin
                exp_t e;
                bit ok;
                e = exp_q.pop_front();
                ok = (rsp_fail == e.fail) && (int'(rsp_way) == e.way) && (rsp_writeback == e.wb)
                     && (rsp_use_clear == e.clr) && (rsp_set_lock == e.lk) && (rsp_set == e.set)
                     && (cyc == e.cyc);
                check(ok, e.tag,
                      $sformatf("fail=%0b way=%0d wb=%0b clr=%h lk=%0b set=%h cyc=%0d",
                                rsp_fail, rsp_way, rsp_writeback, rsp_use_clear, rsp_set_lock, rsp_set, cyc),
                      $sformatf("fail=%0b way=%0d wb=%0b clr=%h lk=%0b set=%h cyc=%0d",
                                e.fail, e.way, e.wb, e.clr, e.lk, e.set, e.cyc));
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "hung", "finished");
            summary();
        end
    end

    initial begin
        for (int r = 0; r <= CORES; r++) model_mask[r] = '0;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !cfg_wr_err && req_ready, "R1 reset outputs",
              $sformatf("v=%0b e=%0b r=%0b", rsp_valid, cfg_wr_err, req_ready), "v=0 e=0 r=1");
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R1 after reset",
              $sformatf("v=%0b r=%0b", rsp_valid, req_ready), "v=0 r=1");

        // R1: all masks open, R6 lowest cold way, R10 dirty victim, R11 set index
        issue(0, 0, 40'h12_3456_7880, 8'hFF, 8'h08, 8'h00, 8'h07, "R6 R10 R11 cold way");
        issue(4, 0, 40'h00_0000_0000, 8'hFF, 8'h00, 8'h00, 8'hFE, "R1 R3 hw open mask");
        // R5 invalid first, even with a cold valid way below it
        issue(1, 0, 40'h00_0001_FF80, 8'hEF, 8'hFF, 8'h00, 8'h00, "R5 invalid first");
        // R7 all use set, open mask
        issue(2, 0, 40'h00_0000_0080, 8'hFF, 8'h01, 8'h00, 8'hFF, "R7 R10 wrap open");
        drain();

        // R3 partition for core 1
        write_mask(1, 8'h0F, 0, "R3 core1 mask");
        issue(1, 0, 40'h0, 8'hFF, 8'h00, 8'h00, 8'hFF, "R3 R7 wrap partitioned");
        issue(1, 0, 40'h0, 8'hF0, 8'h00, 8'h00, 8'h00, "R3 invalid blocked ways");
        issue(0, 0, 40'h0, 8'hFF, 8'h00, 8'h00, 8'hF0, "R3 core0 unaffected");
        // R4 locks
        issue(1, 0, 40'h0, 8'hFF, 8'h00, 8'h30, 8'hFF, "R4 R7 locked skipped");
        issue(1, 0, 40'h0, 8'hEF, 8'hFF, 8'h10, 8'h00, "R4 locked invalid skipped");
        issue(1, 0, 40'h0, 8'hFF, 8'hFF, 8'hF0, 8'h00, "R8 no candidate");
        // R9 lock-fill
        issue(1, 1, 40'h0, 8'hFF, 8'h00, 8'h70, 8'h00, "R9 single spare fails");
        issue(1, 1, 40'h0, 8'hFF, 8'h40, 8'h30, 8'h00, "R9 R10 lock granted");
        drain();

        // hardware-agent mask
        write_mask(4, 8'hFE, 0, "R3 hw mask");
        issue(4, 1, 40'h0, 8'hFF, 8'h00, 8'h00, 8'h00, "R9 hw lock one way");
        issue(4, 0, 40'h0, 8'hFF, 8'h01, 8'h00, 8'hFF, "R3 R7 hw one way");
        issue(5, 0, 40'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R3 R8 unknown source");
        drain();

        // R2 refused writes keep the old mask
        write_mask(1, 8'hFF, 1, "R2 all blocked");
        issue(1, 0, 40'h0, 8'hFF, 8'h00, 8'h00, 8'hFF, "R2 old mask kept");
        drain();
        write_mask(5, 8'h00, 1, "R2 bad selector");
        write_mask(7, 8'h01, 1, "R2 bad selector high");
        issue(1, 0, 40'h0, 8'hFF, 8'h00, 8'h00, 8'h00, "R2 core1 still masked");

        // randomized mix
        for (int k = 0; k < 60; k++) begin
            if (k % 10 == 0) begin
                logic [NW-1:0] m;
                int s;
                s = int'($urandom_range(0, CORES));
                m = NW'($urandom);
                if (k % 20 == 0) m = m | 8'hF0;
                write_mask(s, m, &m, "R2 random write");
            end
            issue(int'($urandom_range(0, CORES + 1)), bit'($urandom_range(0, 1)), AW'({$urandom, $urandom}),
                  NW'($urandom | $urandom), NW'($urandom), NW'($urandom & $urandom), NW'($urandom | $urandom),
                  "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end
        drain();
        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end
endmodule